// File: doc/BRIEF.md
# Escaped MFM Write Stream Formatter

This block sits between a DMA-style byte source and a bit-level MFM write encoder. The incoming stream is mostly plain data, but the byte 0x99 works as an escape: the byte after it is a command, not data. Commands emit sync or address marks with a missing clock, insert the running CRC, open a raw window in which escapes are not decoded, or end the write.

For each emitted byte the block presents a byte, a flag telling the encoder to drop the clock (a mark byte), and a one-cycle valid strobe. It also drives a write gate and a sticky done flag. A CRC-16 (polynomial 0x1021) is kept inside the block. It is preset to 0xFFFF by the first A1 sync mark of a run, and it covers the A1 marks, the address mark and the data. Gap filler (0x4E) and sync filler (0x00) are ordinary literal bytes. Output takes no back-pressure: each accepted byte that produces output appears on the cycle after the handshake.

Top module: `mfm_esc_fmt`

## Requirements
- R1: An accepted byte other than 0x99, outside an escape, is emitted on the next cycle with out_valid_o high for one cycle and out_mark_o low. A cycle without a handshake emits nothing.
- R2: The pair 0x99 0x99 emits one unmarked 0x99 byte, and that byte enters the CRC.
- R3: The pair 0x99 0xA1 emits 0xA1 with out_mark_o high. If the previous emitted byte was not an A1 mark, the CRC is preset to 0xFFFF before the A1 is folded in.
- R4: The pair 0x99 0xC2 emits 0xC2 with out_mark_o high and leaves the CRC unchanged.
- R5: A pair 0x99 followed by 0xFE, 0xFB or 0xFC emits that byte with out_mark_o high, and the byte enters the CRC.
- R6: The pair 0x99 0x0F emits nothing. The next RAW_LEN accepted bytes are emitted literally, including any 0x99, and escape decoding resumes after them.
- R7: The pair 0x99 0x04 emits the CRC high byte and then the low byte on two consecutive cycles, both unmarked. The CRC is CRC-16 with polynomial 0x1021, data fed MSB first, over the bytes since the last preset.
- R8: in_ready_o is low for exactly the cycle in which the CRC low byte is being produced, so no input byte is lost.
- R9: The pair 0x99 0x08 emits nothing. It drops write_gate_o, raises done_o, and holds in_ready_o low until reset.
- R10: Any other byte after 0x99 is dropped without output and sets error_o, which stays high until reset.
- R11: write_gate_o rises together with the first emitted byte and stays high until the stop command.
- R12: After reset out_valid_o, write_gate_o, done_o and error_o are low and in_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Stream byte |
| in_valid_i | input | 1 | Stream byte valid |
| in_ready_o | output | 1 | Block accepts a byte this cycle |
| out_byte_o | output | 8 | Byte to the encoder |
| out_mark_o | output | 1 | Byte is written with a missing clock |
| out_valid_o | output | 1 | out_byte_o is valid this cycle |
| write_gate_o | output | 1 | Write gate to the drive |
| done_o | output | 1 | Stop command has been seen |
| error_o | output | 1 | Unknown command has been seen |

## Verification
The bench builds the block with RAW_LEN set to 6 instead of 512. This lets a short stream cross the end of the raw window and check that escape decoding resumes on the very next byte. Input valid has periodic gaps, so escape pairs and raw bytes are split across idle cycles, and a CRC command is followed at once by more input to test the one-cycle stall. A second run after a mid-stream reset covers an address mark other than 0xFE and a CRC over a different run of bytes.

// File: rtl/mfm_esc_pkg.sv
package mfm_esc_pkg;
  localparam logic [7:0] ESC_BYTE  = 8'h99;
  localparam logic [7:0] CMD_A1    = 8'hA1;
  localparam logic [7:0] CMD_C2    = 8'hC2;
  localparam logic [7:0] CMD_AM_FE = 8'hFE;
  localparam logic [7:0] CMD_AM_FB = 8'hFB;
  localparam logic [7:0] CMD_AM_FC = 8'hFC;
  localparam logic [7:0] CMD_RAW   = 8'h0F;
  localparam logic [7:0] CMD_CRC   = 8'h04;
  localparam logic [7:0] CMD_STOP  = 8'h08;
  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  typedef enum logic [2:0] {S_NORM, S_ESC, S_RAW, S_CRC2, S_DONE} fmt_state_e;

  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/mfm_crc16.sv
module mfm_crc16
  import mfm_esc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        preset_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= CRC_INIT;
    else if (en_i) crc_q <= crc16_step(preset_i ? CRC_INIT : crc_q, data_i);
  end

  assign crc_o = crc_q;

  // R3: a preset fold always starts from the init value
  a_r3_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && preset_i) |=> crc_o == crc16_step(CRC_INIT, $past(data_i)));
endmodule

// File: rtl/mfm_raw_cnt.sv
module mfm_raw_cnt #(
  parameter int RAW_LEN = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output logic last_o
);
  localparam int CW = $clog2(RAW_LEN + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(RAW_LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= LOAD_VAL;
    else if (dec_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CW'(1));

  a_r6_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD_VAL);
  a_r6_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == LOAD_VAL);
endmodule

// File: rtl/mfm_esc_fmt.sv
module mfm_esc_fmt
  import mfm_esc_pkg::*;
#(
  parameter int RAW_LEN = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] in_data_i,
  input  logic       in_valid_i,
  output logic       in_ready_o,
  output logic [7:0] out_byte_o,
  output logic       out_mark_o,
  output logic       out_valid_o,
  output logic       write_gate_o,
  output logic       done_o,
  output logic       error_o
);
  fmt_state_e state_q, state_d;
  logic        take, emit, emit_mark, crc_en, crc_preset;
  logic        raw_load, raw_dec, raw_last, stop, bad;
  logic        a1_q, a1_d;
  logic [7:0]  emit_byte;
  logic [15:0] crc;

  assign in_ready_o = (state_q != S_CRC2) && (state_q != S_DONE);
  assign take       = in_valid_i && in_ready_o;

  mfm_crc16 i_crc (
    .clk_i, .rst_ni, .en_i(crc_en), .preset_i(crc_preset),
    .data_i(in_data_i), .crc_o(crc)
  );

  mfm_raw_cnt #(.RAW_LEN(RAW_LEN)) i_raw (
    .clk_i, .rst_ni, .load_i(raw_load), .dec_i(raw_dec), .last_o(raw_last)
  );

  always_comb begin
    state_d    = state_q;
    a1_d       = a1_q;
    emit       = 1'b0;
    emit_byte  = in_data_i;
    emit_mark  = 1'b0;
    crc_en     = 1'b0;
    crc_preset = 1'b0;
    raw_load   = 1'b0;
    raw_dec    = 1'b0;
    stop       = 1'b0;
    bad        = 1'b0;
    unique case (state_q)
      S_NORM: if (take) begin
        if (in_data_i == ESC_BYTE) state_d = S_ESC;
        else begin emit = 1'b1; crc_en = 1'b1; a1_d = 1'b0; end
      end
      S_ESC: if (take) begin
        state_d = S_NORM;
        unique case (in_data_i)
          ESC_BYTE: begin emit = 1'b1; crc_en = 1'b1; a1_d = 1'b0; end
          CMD_A1: begin
            emit = 1'b1; emit_mark = 1'b1; crc_en = 1'b1;
            crc_preset = !a1_q; a1_d = 1'b1;
          end
          CMD_C2: begin emit = 1'b1; emit_mark = 1'b1; a1_d = 1'b0; end
          CMD_AM_FE, CMD_AM_FB, CMD_AM_FC: begin
            emit = 1'b1; emit_mark = 1'b1; crc_en = 1'b1; a1_d = 1'b0;
          end
          CMD_RAW: begin raw_load = 1'b1; state_d = S_RAW; end
          CMD_CRC: begin
            emit = 1'b1; emit_byte = crc[15:8]; a1_d = 1'b0; state_d = S_CRC2;
          end
          CMD_STOP: begin stop = 1'b1; state_d = S_DONE; end
          default:  bad = 1'b1;
        endcase
      end
      S_RAW: if (take) begin
        emit = 1'b1; crc_en = 1'b1; raw_dec = 1'b1; a1_d = 1'b0;
        if (raw_last) state_d = S_NORM;
      end
      S_CRC2: begin emit = 1'b1; emit_byte = crc[7:0]; state_d = S_NORM; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_NORM;
      a1_q         <= 1'b0;
      out_valid_o  <= 1'b0;
      out_byte_o   <= '0;
      out_mark_o   <= 1'b0;
      write_gate_o <= 1'b0;
      done_o       <= 1'b0;
      error_o      <= 1'b0;
    end else begin
      state_q     <= state_d;
      a1_q        <= a1_d;
      out_valid_o <= emit;
      if (emit) begin
        out_byte_o <= emit_byte;
        out_mark_o <= emit_mark;
      end
      if (stop)      write_gate_o <= 1'b0;
      else if (emit) write_gate_o <= 1'b1;
      if (stop) done_o  <= 1'b1;
      if (bad)  error_o <= 1'b1;
    end
  end

  a_r8_crc_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && state_q == S_ESC && in_data_i == CMD_CRC) |=> !in_ready_o && out_valid_o);
  a_r7_crc_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CRC2) |=> out_valid_o && !out_mark_o && in_ready_o);
  a_r9_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && state_q == S_ESC && in_data_i == CMD_STOP) |=> done_o && !write_gate_o && !out_valid_o);
  a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && !in_ready_o && !write_gate_o);
  a_r10_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o);
  a_r11_gate_with_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> write_gate_o);
  a_r1_idle_no_emit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && state_q != S_CRC2) |=> !out_valid_o);
endmodule

// File: tb/test_mfm_esc_fmt.sv
module test_mfm_esc_fmt;
  localparam int RAW_LEN = 6;
  localparam int ST_NORM = 0, ST_ESC = 1, ST_RAW = 2, ST_CRC2 = 3, ST_DONE = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] din = '0;
  logic vin = 1'b0;
  logic rdy, ov, om, wg, dn, er;
  logic [7:0] ob;

  int tests = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  mfm_esc_fmt #(.RAW_LEN(RAW_LEN)) i_mfm_esc_fmt (
    .clk_i(clk), .rst_ni(rst_n), .in_data_i(din), .in_valid_i(vin),
    .in_ready_o(rdy), .out_byte_o(ob), .out_mark_o(om), .out_valid_o(ov),
    .write_gate_o(wg), .done_o(dn), .error_o(er)
  );

  // reference model state
  int m_st, m_cnt;
  bit m_a1, e_v, e_m, e_g, e_d, e_e;
  logic [15:0] m_crc;
  logic [7:0] e_b;
  string tag;
  byte unsigned q[$];

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    int x;
    x = int'(c) ^ (int'(d) << 8);
    for (int k = 0; k < 8; k++) begin
      x = x << 1;
      if (x & 32'h10000) x = x ^ 32'h11021;
    end
    return x[15:0];
  endfunction

  task automatic check(input bit ok, input string t, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", t, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = ST_NORM; m_cnt = 0; m_a1 = 0; m_crc = 16'hFFFF;
    e_v = 0; e_m = 0; e_g = 0; e_d = 0; e_e = 0; e_b = 0; tag = "R12";
  endtask

  function automatic bit m_ready();
    return m_st != ST_CRC2 && m_st != ST_DONE;
  endfunction

  task automatic compare();
    check(rdy == m_ready(), "R8 ready", rdy, m_ready());
    check(ov == e_v, {tag, " valid"}, ov, e_v);
    if (e_v) begin
      check(ob == e_b, {tag, " byte"}, ob, e_b);
      check(om == e_m, {tag, " mark"}, om, e_m);
    end
    check(wg == e_g, "R11 write gate", wg, e_g);
    check(dn == e_d, "R9 done", dn, e_d);
    check(er == e_e, "R10 error", er, e_e);
  endtask

  // one clock: compare, drive, predict, advance
  task automatic step();
    bit take, nv, nm;
    logic [7:0] nb, d;
    @(negedge clk);
    cyc++;
    compare();
    vin = (q.size() > 0) && (cyc % 5 != 3);
    din = vin ? 8'(q[0]) : 8'h00;
    d = din;
    take = vin && m_ready();
    if (take) void'(q.pop_front());
    nv = 0; nm = 0; nb = d;
    case (m_st)
      ST_NORM: if (take) begin
        if (d == 8'h99) m_st = ST_ESC;
        else begin nv = 1; m_crc = ref_crc(m_crc, d); m_a1 = 0; tag = "R1"; end
      end
      ST_ESC: if (take) begin
        m_st = ST_NORM;
        if (d == 8'h99) begin nv = 1; m_crc = ref_crc(m_crc, d); m_a1 = 0; tag = "R2"; end
        else if (d == 8'hA1) begin
          nv = 1; nm = 1; m_crc = ref_crc(m_a1 ? m_crc : 16'hFFFF, d); m_a1 = 1; tag = "R3";
        end else if (d == 8'hC2) begin nv = 1; nm = 1; m_a1 = 0; tag = "R4"; end
        else if (d == 8'hFE || d == 8'hFB || d == 8'hFC) begin
          nv = 1; nm = 1; m_crc = ref_crc(m_crc, d); m_a1 = 0; tag = "R5";
        end else if (d == 8'h0F) begin m_st = ST_RAW; m_cnt = RAW_LEN; tag = "R6"; end
        else if (d == 8'h04) begin nv = 1; nb = m_crc[15:8]; m_a1 = 0; m_st = ST_CRC2; tag = "R7"; end
        else if (d == 8'h08) begin m_st = ST_DONE; e_g = 0; e_d = 1; tag = "R9"; end
        else begin e_e = 1; tag = "R10"; end
      end
      ST_RAW: if (take) begin
        nv = 1; m_crc = ref_crc(m_crc, d); m_a1 = 0; tag = "R6";
        m_cnt--; if (m_cnt == 0) m_st = ST_NORM;
      end
      ST_CRC2: begin nv = 1; nb = m_crc[7:0]; m_st = ST_NORM; tag = "R7"; end
      default: ;
    endcase
    @(posedge clk);
    #1;
    e_v = nv;
    if (nv) begin e_b = nb; e_m = nm; e_g = 1; end
  endtask

  task automatic push(input byte unsigned b[]);
    foreach (b[k]) q.push_back(b[k]);
  endtask

  task automatic run_until_empty(input int extra);
    while (q.size() > 0) step();
    repeat (extra) step();
  endtask

  task automatic reset_check();
    @(negedge clk);
    rst_n = 1'b0; vin = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    check(!ov && !wg && !dn && !er, "R12 outputs after reset", {ov, wg, dn, er}, 0);
    check(rdy == 1'b1, "R12 ready after reset", rdy, 1);
    rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    reset_check();
    repeat (2) step();   // R1: idle cycles emit nothing
    // gap, sync, A1 run, address mark, header, CRC
    push('{8'h4E, 8'h4E, 8'h4E, 8'h00, 8'h00,
           8'h99, 8'hA1, 8'h99, 8'hA1, 8'h99, 8'hA1, 8'h99, 8'hFE,
           8'h02, 8'h00, 8'h05, 8'h02, 8'h99, 8'h04, 8'h4E});
    // index mark, escaped data, raw window holding escapes, resume decoding
    push('{8'h99, 8'hC2, 8'h99, 8'h99, 8'h99, 8'h0F,
           8'h99, 8'h99, 8'h12, 8'h99, 8'h08, 8'h34,
           8'h99, 8'h99, 8'h99, 8'hA1, 8'h99, 8'hFB, 8'hAB,
           8'h99, 8'h04, 8'h99, 8'h04, 8'h99, 8'h55, 8'h42, 8'h99, 8'h08,
           8'h11, 8'h22});
    while (m_st != ST_DONE) step();
    repeat (6) step();   // R9: offered bytes stay unaccepted
    check(q.size() == 2, "R9 input held after stop", q.size(), 2);
    q.delete();
    reset_check();
    push('{8'h99, 8'hA1, 8'h99, 8'hFC, 8'h12, 8'h34, 8'h99, 8'h04,
           8'h99, 8'hA1, 8'h99, 8'hA1, 8'h99, 8'h04, 8'h99, 8'h08});
    run_until_empty(4);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule